// File: doc/BRIEF.md
# Fast Ethernet Receive Symbol Decoder

This block takes the recovered serial line bit of a 100 Mb/s twisted-pair receiver, one bit per cycle of the 125 MHz bit clock, and turns it into the 4-bit receive nibble stream of a media-independent interface. It undoes the NRZI line coding. It strips the scrambler keystream with an 11-stage descrambler that trains itself on the idle stream. It finds the code-group boundary from the start-of-stream delimiter and maps each 5-bit code group to a data nibble. It also generates the receive data-valid and receive-error signals, and a receive clock divided by five from the bit clock.

The receive state machine has three states. ST_HUNT looks for the start delimiter: group J (11000) followed by group K (10001), first bit on the wire leftmost. ST_FRAME decodes data groups. ST_TAIL waits for the group that must follow a T group. The transitions are:
- HUNT_TO_FRAME: the delimiter is seen, and the descrambler is locked or bypass is set.
- FRAME_TO_TAIL: a T group (01101) is seen.
- FRAME_TO_HUNT: an idle group (11111) arrives inside a frame.
- TAIL_TO_HUNT: the group after T, whatever it is.

In all other cases the state holds.

A static bypass input skips both the descrambler and the group decoder. In bypass, each raw 5-bit group is shown on the receive pins, with the receive-error pin carrying the group's first bit. Framing and data-valid work exactly as in normal mode.

Top module: `fe_rx_symdec`

## Requirements
- R1: A change of `line_in` level between two consecutive bit-clock cycles is a 1 bit, and no change is a 0 bit.
- R2: `rx_clk` runs continuously at one fifth of the bit clock, whether or not data is present: high for 2 cycles, low for 3. It is never high for more than 2 consecutive cycles.
- R3: `rxd`, `rx_dv` and `rx_er` change only on the edge where `rx_clk` falls or stays low, so they are stable at the rising edge of `rx_clk`.
- R4: The descrambler uses the keystream of x^11 + x^9 + 1 and XORs it with each bit. It locks after LOCK_RUN consecutive bits that decode as idle ones, and no delimiter is accepted in normal mode before lock.
- R5: The delimiter J (11000) then K (10001) realigns the group boundary so that the next 5 bits form the first data group. The period that follows the delimiter shows `rxd`=0101 with `rx_dv` low (in bypass: the raw K group).
- R6: In a frame, each data group drives `rx_dv` high and `rxd` to its nibble from the standard 4B/5B table (for example 0 from 11110, 5 from 01011, F from 11101).
- R7: In normal mode, a group in a frame that is neither data, idle nor T (for example 00000) drives `rx_er` high and `rxd` to 0000 for that period, with `rx_dv` kept high.
- R8: A T group drops `rx_dv` and `rxd` to 0. If the next group is R (00111), `rx_er` stays low. Otherwise `rx_er` is high with `rx_dv` low for that one period. Either way the block returns to hunting.
- R9: An idle group inside a frame drops `rx_dv` with `rx_er` low and returns to hunting.
- R10: In normal mode, whenever `rx_dv` is low, `rxd` is 0000 (or 0101 right after the delimiter), and `rx_er` is low except in the case of R8.
- R11: With `bypass` high, no descrambling is done. Every period shows the raw group on {`rx_er`,`rxd`}, and `rx_dv` framing follows R5, R6, R8 and R9.
- R12: During reset, `rxd`, `rx_dv`, `rx_er` and `rx_clk` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 125 MHz recovered bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 1 | Recovered NRZI line bit, one per clock |
| bypass | input | 1 | Static: skip descrambler and decoder, show raw groups |
| rxd | output | 4 | Receive nibble (bypass: low four bits of the raw group) |
| rx_dv | output | 1 | Receive data valid |
| rx_er | output | 1 | Receive error (bypass: first bit of the raw group) |
| rx_clk | output | 1 | Receive clock, bit clock divided by five |

## Verification
The assertions check the following on every cycle: outputs move only while the receive clock is low, the receive clock is never high for more than two cycles, data-valid rises only after the 0101 delimiter nibble, an error inside a frame blanks the nibble, and outside a frame only the idle or delimiter nibble appears. Other behaviours show up only in the bench's frame scenarios. These are the descrambler lock on a randomly seeded scrambled stream, the correctness of every decoded nibble, the end-of-stream handling for T/R, for T followed by a non-R group and for an early idle, and the raw-group mode.

// File: rtl/fe_rx_pkg.sv
package fe_rx_pkg;
    localparam int GRP_W = 5;
    localparam int NIB_W = 4;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_FRAME,
        ST_TAIL
    } rx_state_t;

    typedef enum logic [2:0] {
        GK_DATA,
        GK_IDLE,
        GK_TERM,
        GK_RESET,
        GK_BAD
    } grp_kind_t;

    localparam logic [2*GRP_W-1:0] SSD_PAT      = 10'b11000_10001;
    localparam logic [GRP_W-1:0]   CG_IDLE      = 5'b11111;
    localparam logic [GRP_W-1:0]   CG_TERM      = 5'b01101;
    localparam logic [GRP_W-1:0]   CG_RESET     = 5'b00111;
    localparam logic [NIB_W-1:0]   PREAMBLE_NIB = 4'b0101;
endpackage

// File: rtl/fe_rx_nrzi.sv
module fe_rx_nrzi (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic nrz_out
);
    logic prev_lvl;

    // a level change is a one, no change is a zero
    assign nrz_out = line_in ^ prev_lvl;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_lvl <= 1'b0;
        else        prev_lvl <= line_in;
    end
endmodule

// File: rtl/fe_rx_descram.sv
module fe_rx_descram #(
    parameter int LFSR_W   = 11,
    parameter int LFSR_TAP = 9,
    parameter int LOCK_RUN = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic nrz_in,
    output logic plain_out,
    output logic locked
);
    localparam int RUN_W = $clog2(LOCK_RUN + 1);

    logic [LFSR_W-1:0] lfsr;
    logic [RUN_W-1:0]  run;
    logic              key;

    assign key       = lfsr[LFSR_W-1] ^ lfsr[LFSR_TAP-1];
    assign plain_out = nrz_in ^ key;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lfsr   <= '0;
            run    <= '0;
            locked <= 1'b0;
        end else if (locked) begin
            lfsr <= {lfsr[LFSR_W-2:0], key};
        end else begin
            // training: assume idle ones, so the keystream is the inverted line bit
            lfsr <= {lfsr[LFSR_W-2:0], ~nrz_in};
            if (plain_out) begin
                if (run == RUN_W'(LOCK_RUN - 1)) locked <= 1'b1;
                run <= run + 1'b1;
            end else begin
                run <= '0;
            end
        end
    end
endmodule

// File: rtl/fe_rx_grp_dec.sv
module fe_rx_grp_dec
    import fe_rx_pkg::*;
(
    input  logic [GRP_W-1:0] grp,
    output grp_kind_t        kind,
    output logic [NIB_W-1:0] nib
);
    always_comb begin
        kind = GK_DATA;
        nib  = '0;
        case (grp)
            5'b11110: nib = 4'h0;
            5'b01001: nib = 4'h1;
            5'b10100: nib = 4'h2;
            5'b10101: nib = 4'h3;
            5'b01010: nib = 4'h4;
            5'b01011: nib = 4'h5;
            5'b01110: nib = 4'h6;
            5'b01111: nib = 4'h7;
            5'b10010: nib = 4'h8;
            5'b10011: nib = 4'h9;
            5'b10110: nib = 4'hA;
            5'b10111: nib = 4'hB;
            5'b11010: nib = 4'hC;
            5'b11011: nib = 4'hD;
            5'b11100: nib = 4'hE;
            5'b11101: nib = 4'hF;
            CG_IDLE:  kind = GK_IDLE;
            CG_TERM:  kind = GK_TERM;
            CG_RESET: kind = GK_RESET;
            default:  kind = GK_BAD;
        endcase
    end
endmodule

// File: rtl/fe_rx_symdec.sv
module fe_rx_symdec
    import fe_rx_pkg::*;
#(
    parameter int LFSR_W   = 11,
    parameter int LFSR_TAP = 9,
    parameter int LOCK_RUN = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_in,
    input  logic             bypass,
    output logic [NIB_W-1:0] rxd,
    output logic             rx_dv,
    output logic             rx_er,
    output logic             rx_clk
);
    localparam int CNT_W = $clog2(GRP_W);
    localparam int WIN_W = 2 * GRP_W;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(GRP_W - 1);
    localparam logic [CNT_W-1:0] CNT_HIGH = CNT_W'(GRP_W - 2);

    logic nrz_bit, plain_bit, scr_locked, data_bit;

    fe_rx_nrzi u_nrzi (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (line_in),
        .nrz_out (nrz_bit)
    );

    fe_rx_descram #(
        .LFSR_W   (LFSR_W),
        .LFSR_TAP (LFSR_TAP),
        .LOCK_RUN (LOCK_RUN)
    ) u_descram (
        .clk       (clk),
        .rst_n     (rst_n),
        .nrz_in    (nrz_bit),
        .plain_out (plain_bit),
        .locked    (scr_locked)
    );

    assign data_bit = bypass ? nrz_bit : plain_bit;

    logic [WIN_W-1:0] win, win_n;
    logic [GRP_W-1:0] grp;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic             grp_done, ssd_hit;
    grp_kind_t        kind;
    logic [NIB_W-1:0] nib;
    rx_state_t        state, state_n;

    assign win_n    = {win[WIN_W-2:0], data_bit};
    assign grp      = win_n[GRP_W-1:0];
    assign grp_done = (cnt == CNT_LAST);
    assign ssd_hit  = (state == ST_HUNT) && (scr_locked || bypass) && (win_n == SSD_PAT);

    fe_rx_grp_dec u_dec (
        .grp  (grp),
        .kind (kind),
        .nib  (nib)
    );

    // next state and bit counter
    always_comb begin
        state_n = state;
        cnt_n   = grp_done ? '0 : cnt + 1'b1;
        if (ssd_hit) begin
            state_n = ST_FRAME;
            cnt_n   = '0;
        end else if (grp_done) begin
            unique case (state)
                ST_HUNT:  state_n = ST_HUNT;
                ST_FRAME: begin
                    if (kind == GK_IDLE)      state_n = ST_HUNT;
                    else if (kind == GK_TERM) state_n = ST_TAIL;
                end
                ST_TAIL:  state_n = ST_HUNT;
                default:  state_n = ST_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_HUNT;
            cnt   <= '0;
            win   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
            win   <= win_n;
        end
    end

    // output values
    logic [NIB_W-1:0] rxd_n;
    logic             dv_n, er_n, rclk_n;

    always_comb begin
        rxd_n  = rxd;
        dv_n   = rx_dv;
        er_n   = rx_er;
        rclk_n = (cnt_n >= CNT_HIGH);
        if (ssd_hit) begin
            dv_n  = 1'b0;
            rxd_n = PREAMBLE_NIB;
            er_n  = 1'b0;
        end else if (grp_done) begin
            rxd_n = '0;
            er_n  = 1'b0;
            dv_n  = 1'b0;
            unique case (state)
                ST_HUNT: dv_n = 1'b0;
                ST_FRAME: begin
                    unique case (kind)
                        GK_DATA:  begin dv_n = 1'b1; rxd_n = nib; end
                        GK_IDLE:  dv_n = 1'b0;
                        GK_TERM:  dv_n = 1'b0;
                        GK_RESET: begin dv_n = 1'b1; er_n = 1'b1; end
                        GK_BAD:   begin dv_n = 1'b1; er_n = 1'b1; end
                        default:  begin dv_n = 1'b1; er_n = 1'b1; end
                    endcase
                end
                ST_TAIL: er_n = (kind != GK_RESET);
                default: dv_n = 1'b0;
            endcase
        end
        if (bypass && (ssd_hit || grp_done)) begin
            {er_n, rxd_n} = grp;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxd    <= '0;
            rx_dv  <= 1'b0;
            rx_er  <= 1'b0;
            rx_clk <= 1'b0;
        end else begin
            rxd    <= rxd_n;
            rx_dv  <= dv_n;
            rx_er  <= er_n;
            rx_clk <= rclk_n;
        end
    end
endmodule

// File: rtl/fe_rx_symdec_chk.sv
module fe_rx_symdec_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bypass,
    input logic [3:0] rxd,
    input logic       rx_dv,
    input logic       rx_er,
    input logic       rx_clk
);
    // R3: outputs only move where the receive clock is low
    a_r3_change_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({rx_er, rx_dv, rxd}) |-> !rx_clk);

    // R2: receive clock high for at most two cycles
    a_r2_clk_high_max: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_clk && $past(rx_clk)) |=> !rx_clk);

    // R5: data valid rises only after the delimiter nibble
    a_r5_dv_after_preamble: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && $rose(rx_dv)) |-> ($past(rxd) == 4'b0101 && !$past(rx_er)));

    // R7: an error inside a frame blanks the nibble
    a_r7_err_blank: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && rx_dv && rx_er) |-> (rxd == 4'b0000));

    // R10: outside a frame only idle or delimiter nibbles appear
    a_r10_quiet_nibble: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && !rx_dv) |-> (rxd == 4'b0000 || rxd == 4'b0101));
endmodule

bind fe_rx_symdec fe_rx_symdec_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .bypass (bypass),
    .rxd    (rxd),
    .rx_dv  (rx_dv),
    .rx_er  (rx_er),
    .rx_clk (rx_clk)
);

// File: tb/fe_rx_symdec_bench.sv
module fe_rx_symdec_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_in = 1'b0;
    logic       bypass = 1'b0;
    logic [3:0] rxd;
    logic       rx_dv, rx_er, rx_clk;

    always #2 clk = ~clk;

    fe_rx_symdec u_fe_rx_symdec (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (line_in),
        .bypass  (bypass),
        .rxd     (rxd),
        .rx_dv   (rx_dv),
        .rx_er   (rx_er),
        .rx_clk  (rx_clk)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // capture {dv, er, rxd} at every rising edge of rx_clk
    logic [5:0] cap [0:4095];
    int         cap_n = 0;
    logic       rclk_prev = 1'b0;

    always @(negedge clk) begin
        if (rst_n && rx_clk && !rclk_prev && cap_n < 4096) begin
            cap[cap_n] = {rx_dv, rx_er, rxd};
            cap_n++;
        end
        rclk_prev = rx_clk;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [5:0] act, input logic [5:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // transmit side model
    logic        line_lvl = 1'b0;
    logic [10:0] tx_s = 11'h1;

    function automatic logic [4:0] enc(input logic [3:0] n);
        case (n)
            4'h0: enc = 5'b11110; 4'h1: enc = 5'b01001; 4'h2: enc = 5'b10100; 4'h3: enc = 5'b10101;
            4'h4: enc = 5'b01010; 4'h5: enc = 5'b01011; 4'h6: enc = 5'b01110; 4'h7: enc = 5'b01111;
            4'h8: enc = 5'b10010; 4'h9: enc = 5'b10011; 4'hA: enc = 5'b10110; 4'hB: enc = 5'b10111;
            4'hC: enc = 5'b11010; 4'hD: enc = 5'b11011; 4'hE: enc = 5'b11100; default: enc = 5'b11101;
        endcase
    endfunction

    task automatic send_bit(input logic b);
        logic k, o;
        k = tx_s[10] ^ tx_s[8];
        o = bypass ? b : (b ^ k);
        tx_s = {tx_s[9:0], k};
        if (o) line_lvl = ~line_lvl;
        @(negedge clk);
        line_in = line_lvl;
    endtask

    task automatic send_grp(input logic [4:0] g);
        for (int i = 4; i >= 0; i--) send_bit(g[i]);
    endtask

    task automatic do_reset(input logic byp);
        rst_n    = 1'b0;
        bypass   = byp;
        line_lvl = 1'b0;
        line_in  = 1'b0;
        tx_s     = 11'($urandom) | 11'h1;
        repeat (4) @(negedge clk);
        chk({rx_dv, rx_er, rxd, rx_clk} == 7'b0, "R12 reset state",
            {rx_dv, rx_er, rxd}, 6'b0);
        rst_n = 1'b1;
    endtask

    logic [3:0] fdat [0:63];
    logic [4:0] fraw [0:63];

    // end_kind: 0 = T then R, 1 = idle inside frame, 2 = T then idle
    task automatic run_frame(input int n, input int end_kind, input int bad_pos);
        int start, p, q;
        logic [5:0] e;
        start = cap_n;
        p = -1;
        for (int i = 0; i < n; i++) begin
            fdat[i] = 4'($urandom);
            fraw[i] = (i == bad_pos) ? 5'b00000 : enc(fdat[i]);
        end
        send_grp(5'b11111);
        send_grp(5'b11111);
        send_grp(5'b11000);
        send_grp(5'b10001);
        for (int i = 0; i < n; i++) send_grp(fraw[i]);
        case (end_kind)
            0: begin send_grp(5'b01101); send_grp(5'b00111); end
            1: send_grp(5'b11111);
            default: begin send_grp(5'b01101); send_grp(5'b11111); end
        endcase
        for (int i = 0; i < 6; i++) send_grp(5'b11111);
        for (int j = start; j < cap_n - 1; j++) begin
            if (p < 0 && !cap[j][5] && cap[j+1][5] &&
                (bypass ? (cap[j][4:0] == 5'b10001) : (cap[j][4:0] == 5'b00101))) p = j;
        end
        chk(p >= 0, "R5 delimiter nibble before first valid", 6'(p >= 0), 6'd1);
        if (p < 0) return;
        // R1 R4 R6 R7 R11: every data period
        for (int i = 0; i < n; i++) begin
            if (bypass)             e = {1'b1, fraw[i]};
            else if (i == bad_pos)  e = 6'b110000;
            else                    e = {2'b10, fdat[i]};
            chk(cap[p+1+i] == e, bypass ? "R11 raw group" :
                (i == bad_pos) ? "R7 invalid group" : "R6 R4 R1 data nibble", cap[p+1+i], e);
        end
        q = p + 1 + n;
        case (end_kind)
            0: begin
                e = bypass ? 6'b001101 : 6'b000000;
                chk(cap[q] == e, "R8 T drops valid", cap[q], e);
                e = bypass ? 6'b000111 : 6'b000000;
                chk(cap[q+1] == e, "R8 R keeps error low", cap[q+1], e);
            end
            1: begin
                e = bypass ? 6'b011111 : 6'b000000;
                chk(cap[q] == e, "R9 idle ends frame", cap[q], e);
            end
            default: begin
                chk(cap[q] == 6'b000000, "R8 T drops valid", cap[q], 6'b000000);
                chk(cap[q+1] == 6'b010000, "R8 T without R flags error", cap[q+1], 6'b010000);
            end
        endcase
        e = bypass ? 6'b011111 : 6'b000000;
        chk(cap[q+3] == e, "R10 quiet after frame", cap[q+3], e);
    endtask

    initial begin
        int rises, highs;
        logic pv;
        void'($urandom(32'd7351));
        do_reset(1'b0);

        // R2 R3: receive clock runs with a steady line
        rises = 0; highs = 0; pv = 1'b0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (rx_clk && !pv) rises++;
            if (rx_clk) highs++;
            pv = rx_clk;
        end
        chk(rises == 20, "R2 clock rate without data", 6'(rises), 6'd20);
        chk(highs == 40, "R2 clock duty", 6'(highs), 6'd40);

        for (int i = 0; i < 20; i++) send_grp(5'b11111);

        // normal mode frames
        run_frame(1, 0, -1);
        run_frame(16, 0, -1);
        for (int k = 0; k < 4; k++) run_frame(1 + int'($urandom % 30), 0, -1);
        run_frame(10, 0, 4);
        run_frame(8, 1, -1);
        run_frame(5, 2, -1);
        run_frame(12, 0, 0);

        // raw-group mode
        do_reset(1'b1);
        for (int i = 0; i < 6; i++) send_grp(5'b11111);
        run_frame(9, 0, -1);
        run_frame(1 + int'($urandom % 20), 0, -1);
        run_frame(6, 1, -1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule